// File: doc/BRIEF.md
# Paged write buffer and address counter

This block holds the current word address and a 64-byte page load buffer for a 32K x 8 serial memory. A bus front end drives it with plain strobes: an address load, write-byte beats, read-advance pulses, a clear after a control-register read, a commit request and an abort. Data bytes arrive on a valid/ready stream. The block records each loaded byte in a slot of the page buffer and keeps a mask of the slots that hold a byte. A commit then sends only those bytes to an array model, one byte per accepted beat.

The 15-bit address splits into a 9-bit page number (bits 14..6) and a 6-bit byte offset (bits 5..0). A write moves only the offset, so writes wrap inside the page. A read advance moves the whole address, so reads wrap across the full array. If more than 64 bytes are loaded, a later byte replaces the earlier byte at the same offset in place.

Back-pressure rules are as follows. A write beat is taken only on a cycle where `wr_valid` and `wr_ready` are both high. On the array side, a beat is offered with `arr_valid` and completes on a cycle where `arr_ready` is high. While it waits, the offered beat holds its address and data unchanged.

Top module: `pgbuf_addr_ctr`

## Requirements
- R1: After reset, `cur_addr` is 0, `busy` and `arr_valid` are low, `wr_ready` is high and no byte is loaded.
- R2: An accepted address load copies `addr_in` into `cur_addr` on the next cycle and discards every loaded byte.
- R3: An accepted write beat stores `wr_data` at the offset `cur_addr[5:0]` and marks that slot loaded. It then adds one to the offset modulo 64 and leaves the page `cur_addr[14:6]` unchanged.
- R4: When more than 64 bytes are loaded, a later byte replaces the earlier one at the same offset. Each offset is transferred at most once per commit.
- R5: A read advance adds one to the full 15-bit `cur_addr`, so 7FFFh is followed by 0000h.
- R6: A control-register-read-done pulse clears `cur_addr` to 0.
- R7: A commit with at least one loaded byte raises `busy` on the next cycle. Only loaded slots are then transferred, in ascending offset order, with `arr_addr` = {current page, offset} and `arr_data` = the stored byte. `busy` falls the cycle after the last accepted beat, and after that no slot is loaded. A commit with nothing loaded has no effect. A commit never changes `cur_addr`.
- R8: While `arr_valid` is high and `arr_ready` is low, `arr_valid`, `arr_addr` and `arr_data` are held on the next cycle.
- R9: While `busy` is high, `wr_ready` is low, every control input is ignored and `cur_addr` is held.
- R10: An abort discards every loaded byte without touching the array, so a commit that follows it transfers nothing.
- R11: When idle, at most one command acts per cycle, in this priority: abort, commit, address load, control-register clear, write beat, read advance. `wr_ready` is low whenever any of the first four is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_ld | input | 1 | Load `addr_in` into the address counter |
| addr_in | input | 15 | Address to load |
| wr_valid | input | 1 | Write byte stream valid |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte stream ready |
| rd_adv | input | 1 | Read advance pulse |
| creg_rd_done | input | 1 | Control-register read finished; clears the counter |
| commit_req | input | 1 | Transfer the loaded bytes to the array |
| abort_req | input | 1 | Discard the loaded bytes |
| busy | output | 1 | Commit transfer in progress |
| cur_addr | output | 15 | Current word address |
| arr_valid | output | 1 | Array write beat valid |
| arr_ready | input | 1 | Array write beat accepted |
| arr_addr | output | 15 | Array write address |
| arr_data | output | 8 | Array write byte |

## Verification
The assertions watch several rules on every cycle:
- the single-step moves of the counter for loads, writes, read advances and the control-register clear, including the in-page offset wrap;
- the freezing of the counter and of `wr_ready` while busy;
- the stability of an offered array beat under back-pressure;
- the match between the array page and the counter page;
- the rule that an abort followed by a commit raises no busy.

Other behaviour can only be shown by the bench's scenarios, which compare each cycle against a behavioural model:
- which bytes are transferred, and in what order;
- in-place overwrite after more than 64 loads;
- the wrap from 7FFFh to 0000h;
- the priority between inputs that arrive together.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  // One command acts per idle cycle; the decoder in the top picks it by priority.
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ABORT,
    OP_COMMIT,
    OP_LOAD,
    OP_CRCLR,
    OP_WRITE,
    OP_READ
  } op_e;
endpackage

// File: rtl/pgb_addr_ctr.sv
module pgb_addr_ctr
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  {page_q, ofs_q} <= load_val;
        OP_CRCLR: {page_q, ofs_q} <= '0;
        OP_WRITE: ofs_q <= ofs_q + OFS_W'(1);                       // wrap in page
        OP_READ:  {page_q, ofs_q} <= {page_q, ofs_q} + ADDR_W'(1);  // wrap in array
        default: ;
      endcase
    end
  end

  assign addr = {page_q, ofs_q};
endmodule

// File: rtl/pgb_page_store.sv
module pgb_page_store
  import pgbuf_pkg::*;
#(
  parameter int OFS_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  op_e                     op,
  input  logic [OFS_W-1:0]        wr_ofs,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    drain_take,
  input  logic [OFS_W-1:0]        drain_ofs,
  output logic [(1<<OFS_W)-1:0]   mask,
  output logic [DATA_W-1:0]       drain_data
);
  localparam int DEPTH = 1 << OFS_W;

  logic              loaded_q [DEPTH];
  logic [DATA_W-1:0] slot_q   [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic hit_wr, hit_take;
    assign hit_wr   = (op == OP_WRITE) && (wr_ofs == OFS_W'(s));
    assign hit_take = drain_take && (drain_ofs == OFS_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               loaded_q[s] <= 1'b0;
      else if (op == OP_ABORT || op == OP_LOAD) loaded_q[s] <= 1'b0;
      else if (hit_wr)                          loaded_q[s] <= 1'b1;
      else if (hit_take)                        loaded_q[s] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (hit_wr) slot_q[s] <= wr_data;
    end

    assign mask[s] = loaded_q[s];
  end

  assign drain_data = slot_q[drain_ofs];
endmodule

// File: rtl/pgb_drain.sv
module pgb_drain #(
  parameter int OFS_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [(1<<OFS_W)-1:0] mask,
  input  logic                  arr_ready,
  output logic                  busy,
  output logic                  take,
  output logic [OFS_W-1:0]      pick_ofs
);
  localparam int DEPTH = 1 << OFS_W;

  logic                 busy_q;
  logic [DEPTH-1:0]     rest;

  // Lowest loaded slot wins: scan from the top so the last hit is the lowest.
  always_comb begin
    pick_ofs = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (mask[i]) pick_ofs = OFS_W'(i);
    end
  end

  assign rest = mask & ~(DEPTH'(1) << pick_ofs);
  assign take = busy_q && arr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (!busy_q) busy_q <= start && (|mask);
    else if (take)    busy_q <= |rest;
  end

  assign busy = busy_q;
endmodule

// File: rtl/pgbuf_addr_ctr.sv
module pgbuf_addr_ctr
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_adv,
  input  logic              creg_rd_done,
  input  logic              commit_req,
  input  logic              abort_req,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int DEPTH  = 1 << OFS_W;

  op_e              op;
  logic             take;
  logic [OFS_W-1:0] pick_ofs;
  logic [DEPTH-1:0] mask;

  // Priority: abort, commit, load, control-register clear, write, read.
  always_comb begin
    op = OP_IDLE;
    if (!busy) begin
      if (abort_req)         op = OP_ABORT;
      else if (commit_req)   op = OP_COMMIT;
      else if (addr_ld)      op = OP_LOAD;
      else if (creg_rd_done) op = OP_CRCLR;
      else if (wr_valid)     op = OP_WRITE;
      else if (rd_adv)       op = OP_READ;
    end
  end

  assign wr_ready = !busy && !abort_req && !commit_req && !addr_ld && !creg_rd_done;

  pgb_addr_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .load_val (addr_in),
    .addr     (cur_addr)
  );

  pgb_page_store #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .wr_ofs     (cur_addr[OFS_W-1:0]),
    .wr_data    (wr_data),
    .drain_take (take),
    .drain_ofs  (pick_ofs),
    .mask       (mask),
    .drain_data (arr_data)
  );

  pgb_drain #(.OFS_W(OFS_W)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (op == OP_COMMIT),
    .mask      (mask),
    .arr_ready (arr_ready),
    .busy      (busy),
    .take      (take),
    .pick_ofs  (pick_ofs)
  );

  assign arr_valid = busy;
  assign arr_addr  = {cur_addr[ADDR_W-1 -: PAGE_W], pick_ofs};
endmodule

// File: rtl/pgb_checker.sv
module pgb_checker #(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_ld,
  input logic [ADDR_W-1:0] addr_in,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_adv,
  input logic              creg_rd_done,
  input logic              commit_req,
  input logic              abort_req,
  input logic              busy,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              arr_valid,
  input logic              arr_ready,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [DATA_W-1:0] arr_data
);
  logic hi_cmd;
  assign hi_cmd = abort_req || commit_req || addr_ld || creg_rd_done;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ld && !busy && !abort_req && !commit_req |=> cur_addr == $past(addr_in));

  assert_write_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=>
      cur_addr[ADDR_W-1:OFS_W] == $past(cur_addr[ADDR_W-1:OFS_W]) &&
      cur_addr[OFS_W-1:0] == OFS_W'($past(cur_addr[OFS_W-1:0]) + 1'b1));

  assert_read_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv && !busy && !hi_cmd && !wr_valid |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

  assert_creg_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    creg_rd_done && !busy && !abort_req && !commit_req && !addr_ld |=> cur_addr == '0);

  assert_page_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |-> arr_addr[ADDR_W-1:OFS_W] == cur_addr[ADDR_W-1:OFS_W]);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(arr_valid && arr_ready));

  assert_hold_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && !arr_ready |=> arr_valid && $stable(arr_addr) && $stable(arr_data));

  assert_ready_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_addr));

  assert_abort_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req && !busy ##1 commit_req |=> !busy);

  assert_ready_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cmd |-> !wr_ready);
endmodule

bind pgbuf_addr_ctr pgb_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) i_pgb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_ld      (addr_ld),
  .addr_in      (addr_in),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .rd_adv       (rd_adv),
  .creg_rd_done (creg_rd_done),
  .commit_req   (commit_req),
  .abort_req    (abort_req),
  .busy         (busy),
  .cur_addr     (cur_addr),
  .arr_valid    (arr_valid),
  .arr_ready    (arr_ready),
  .arr_addr     (arr_addr),
  .arr_data     (arr_data)
);

// File: tb/test_pgbuf_addr_ctr.sv
`timescale 1ns/1ps
module test_pgbuf_addr_ctr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_ld = 1'b0;
  logic [14:0] addr_in = '0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        wr_ready;
  logic        rd_adv = 1'b0;
  logic        creg_rd_done = 1'b0;
  logic        commit_req = 1'b0;
  logic        abort_req = 1'b0;
  logic        busy;
  logic [14:0] cur_addr;
  logic        arr_valid;
  logic        arr_ready = 1'b1;
  logic [14:0] arr_addr;
  logic [7:0]  arr_data;

  always #5 clk = ~clk;

  pgbuf_addr_ctr i_pgbuf_addr_ctr (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_adv(rd_adv), .creg_rd_done(creg_rd_done), .commit_req(commit_req),
    .abort_req(abort_req), .busy(busy), .cur_addr(cur_addr),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_addr(arr_addr),
    .arr_data(arr_data)
  );

  int    compared = 0;
  int    mismatched = 0;
  bit    cmp_on = 0;
  bit    done = 0;
  bit    rnd_rdy = 0;
  string tag = "R1";
  int    hs_cnt = 0;

  // Behavioural reference model
  bit       mv [64];
  bit [7:0] md [64];
  int       m_addr = 0;
  bit       m_busy = 0;

  function automatic int m_pick();
    for (int i = 0; i < 64; i++) if (mv[i]) return i;
    return 0;
  endfunction

  function automatic bit m_any();
    for (int i = 0; i < 64; i++) if (mv[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_busy = 0;
      for (int i = 0; i < 64; i++) mv[i] = 0;
    end else if (m_busy) begin
      if (arr_ready) begin
        hs_cnt++;
        mv[m_pick()] = 0;
        m_busy = m_any();
      end
    end else if (abort_req) begin
      for (int i = 0; i < 64; i++) mv[i] = 0;
    end else if (commit_req) begin
      m_busy = m_any();
    end else if (addr_ld) begin
      m_addr = int'(addr_in);
      for (int i = 0; i < 64; i++) mv[i] = 0;
    end else if (creg_rd_done) begin
      m_addr = 0;
    end else if (wr_valid) begin
      int o;
      o = m_addr % 64;
      mv[o] = 1; md[o] = wr_data;
      m_addr = (m_addr / 64) * 64 + (o + 1) % 64;
    end else if (rd_adv) begin
      m_addr = (m_addr + 1) % 32768;
    end
  end

  task automatic chk(input string name, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("busy", 32'(busy), 32'(m_busy));
      chk("cur_addr", 32'(cur_addr), 32'(m_addr));
      chk("wr_ready", 32'(wr_ready),
          32'(!m_busy && !abort_req && !commit_req && !addr_ld && !creg_rd_done));
      chk("arr_valid", 32'(arr_valid), 32'(m_busy));
      if (m_busy) begin
        chk("arr_addr", 32'(arr_addr), 32'((m_addr / 64) * 64 + m_pick()));
        chk("arr_data", 32'(arr_data), 32'(md[m_pick()]));
      end
    end
  end

  task automatic cyc(input bit ld, input logic [14:0] ain, input bit wv, input logic [7:0] wd,
                     input bit rd, input bit cr, input bit cm, input bit ab);
    addr_ld = ld; addr_in = ain; wr_valid = wv; wr_data = wd;
    rd_adv = rd; creg_rd_done = cr; commit_req = cm; abort_req = ab;
    arr_ready = rnd_rdy ? 1'($urandom_range(0, 1)) : 1'b1;
    @(posedge clk); #2;
  endtask

  task automatic t_idle();             cyc(0, '0, 0, '0, 0, 0, 0, 0); endtask
  task automatic t_load(input logic [14:0] a); cyc(1, a, 0, '0, 0, 0, 0, 0); endtask
  task automatic t_wr(input logic [7:0] d);    cyc(0, '0, 1, d, 0, 0, 0, 0); endtask
  task automatic t_rd();               cyc(0, '0, 0, '0, 1, 0, 0, 0); endtask
  task automatic t_cr();               cyc(0, '0, 0, '0, 0, 1, 0, 0); endtask
  task automatic t_commit();           cyc(0, '0, 0, '0, 0, 0, 1, 0); endtask
  task automatic t_abort();            cyc(0, '0, 0, '0, 0, 0, 0, 1); endtask

  task automatic wait_drain();
    int n = 0;
    while (m_busy && n < 2000) begin t_idle(); n++; end
    t_idle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired, run hung");
      summary();
      $finish;
    end
  end

  initial begin
    int h0;
    repeat (3) @(posedge clk);
    #2 cmp_on = 1;
    tag = "R1";
    t_idle();
    rst_n = 1'b1;
    t_idle();

    // R2, R3, R7: short load and commit
    tag = "R2"; t_load(15'h1234);
    tag = "R3"; t_wr(8'hA1); t_wr(8'hB2); t_wr(8'hC3);
    tag = "R7"; h0 = hs_cnt; t_commit(); wait_drain();
    chk("R7 transfer count", 32'(hs_cnt - h0), 32'd3);
    chk("R7 counter after commit", 32'(cur_addr), 32'h1237);

    // R7: empty commit does nothing
    t_commit(); t_idle();
    chk("R7 empty commit busy", 32'(busy), 32'd0);

    // R4, R8, R9: overfill from offset 62, drained under back-pressure
    tag = "R4"; t_load(15'h003E);
    for (int i = 0; i < 70; i++) t_wr(8'(i + 8'h40));
    chk("R4 counter offset wrap", 32'(cur_addr), 32'h0004);
    tag = "R8"; rnd_rdy = 1; h0 = hs_cnt; t_commit();
    tag = "R9"; t_wr(8'hEE); t_load(15'h7000); t_rd(); t_cr(); t_abort(); t_commit();
    tag = "R8"; wait_drain(); rnd_rdy = 0;
    chk("R4 transfer count after overfill", 32'(hs_cnt - h0), 32'd64);

    // R5: read advance across the top of the array
    tag = "R5"; t_load(15'h7FFE); t_rd(); t_rd(); t_rd();
    chk("R5 wrap to zero", 32'(cur_addr), 32'h0001);

    // R6: control-register read clears the counter
    tag = "R6"; t_load(15'h2A55); t_cr(); t_idle();
    chk("R6 counter cleared", 32'(cur_addr), 32'h0000);

    // R10: abort then commit transfers nothing
    tag = "R10"; t_load(15'h0440); t_wr(8'h11); t_wr(8'h22);
    h0 = hs_cnt; t_abort(); t_commit(); t_idle(); t_idle();
    chk("R10 no transfer after abort", 32'(hs_cnt - h0), 32'd0);

    // R11: simultaneous commands
    tag = "R11";
    cyc(1, 15'h0100, 1, 8'hAA, 1, 1, 0, 0);
    cyc(0, '0, 1, 8'hBB, 1, 0, 0, 0);
    cyc(0, '0, 0, '0, 1, 1, 0, 0);
    cyc(0, 15'h0200, 1, 8'hCC, 0, 0, 1, 1);
    t_load(15'h0180); t_wr(8'h5A);
    cyc(1, 15'h0300, 1, 8'h00, 0, 0, 1, 0);
    wait_drain();
    chk("R11 commit beat load", 32'(cur_addr), 32'h0181);

    // R2: load discards pending bytes
    tag = "R2"; t_wr(8'h77); t_load(15'h0500); h0 = hs_cnt; t_commit(); t_idle();
    chk("R2 load discards bytes", 32'(hs_cnt - h0), 32'd0);

    // R3 + R7 on a mid-array page with sparse offsets
    tag = "R7"; t_load(15'h5FC0 + 15'd5); t_wr(8'h01); t_wr(8'h02);
    t_load(15'h5FC0 + 15'd60);
    t_wr(8'h03); t_wr(8'h04); t_wr(8'h05); t_wr(8'h06); t_wr(8'h07);
    h0 = hs_cnt; rnd_rdy = 1; t_commit(); wait_drain(); rnd_rdy = 0;
    chk("R7 sparse transfer count", 32'(hs_cnt - h0), 32'd5);
    chk("R3 offset wrap in page", 32'(cur_addr), 32'h5FC1);

    repeat (3) t_idle();
    done = 1;
    summary();
    $finish;
  end
endmodule